// File: doc/BRIEF.md
# Iterative Shift-Add Unsigned Multiplier

This block forms the 64-bit unsigned product of two 32-bit words over 32 clock cycles, one multiplier bit each cycle. A single 64-bit accumulator holds the whole state. Its lower half is loaded with the multiplier and is used up one bit at a time. Its upper half collects partial sums from one 32-bit adder. The carry out of that adder enters the top of the register in the same cycle, so no sum bit is lost.

The user pulses `go` for one cycle with both operands present. The block then raises `running` for 32 cycles. After that it pulses `fin` for one cycle, and the product appears on `prod_hi` and `prod_lo`. Both words keep their values until the next accepted `go`.

Top module: `shiftadd_mul`

## Requirements
- R1: After reset, `running` and `fin` are 0, and `prod_hi` and `prod_lo` are 0.
- R2: A `go` sampled high while `running` is 0 starts an operation. `running` is 1 from the next cycle for exactly 32 cycles.
- R3: `fin` is high for exactly one cycle. That cycle is the first cycle in which `running` is 0 after an operation, which is 33 cycles after the accepted `go` edge.
- R4: When `fin` is high, {`prod_hi`,`prod_lo`} equals the unsigned product of the multiplicand and multiplier sampled with `go`.
- R5: A carry out of the upper-half add is kept. Products that need all 64 bits, for example 0xFFFFFFFF × 0xFFFFFFFF = 0xFFFFFFFE_00000001, are exact.
- R6: A `go` while `running` is 1 is ignored. It does not change the running result, the timing, or the operands used.
- R7: `prod_hi` and `prod_lo` stay unchanged from `fin` until the next accepted `go`, including when no operation is running.
- R8: A zero operand gives a zero product, and an operand of 1 gives the other operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start request, one cycle |
| mcand | input | 32 | Multiplicand |
| mplier | input | 32 | Multiplier |
| running | output | 1 | Operation in progress |
| fin | output | 1 | One-cycle pulse when the result is valid |
| prod_hi | output | 32 | Upper product word |
| prod_lo | output | 32 | Lower product word |

## Verification
A wrong iteration count moves `fin` away from cycle 33 and also shifts the product by a power of two, so the product check and the timing check both report it at the first `fin`. A lost carry or a bad add shows as a wrong `prod_hi` at `fin`, but only for operands whose partial sums overflow 32 bits. All-ones operands are used for that case. A `go` that wrongly restarts the operation leaves `running` high past cycle 32 and changes the product, and this is visible at the original `fin` cycle.

// File: rtl/shiftadd_mul.sv
module shiftadd_mul #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] mcand,
  input  logic [W-1:0] mplier,
  output logic         running,
  output logic         fin,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] prod_lo
);
  localparam int CW = $clog2(W);

  logic [2*W-1:0] acc;
  logic [W-1:0]   mc_q;
  logic [CW-1:0]  cnt;
  logic [W:0]     sum;

  assign sum     = acc[0] ? ({1'b0, acc[2*W-1:W]} + {1'b0, mc_q}) : {1'b0, acc[2*W-1:W]};
  assign prod_hi = acc[2*W-1:W];
  assign prod_lo = acc[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      mc_q    <= '0;
      cnt     <= '0;
      running <= 1'b0;
      fin     <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (running) begin
        acc <= {sum, acc[W-1:1]};
        cnt <= cnt + 1'b1;
        if (cnt == CW'(W-1)) begin
          running <= 1'b0;
          fin     <= 1'b1;
        end
      end else if (go) begin
        acc     <= {{W{1'b0}}, mplier};
        mc_q    <= mcand;
        cnt     <= '0;
        running <= 1'b1;
      end
    end
  end
endmodule

module shiftadd_mul_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         go,
  input logic         running,
  input logic         fin,
  input logic [W-1:0] prod_hi,
  input logic [W-1:0] prod_lo
);
  // R3
  fin_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);
  // R3
  fin_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> fin);
  // R3
  fin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> !running);
  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !running) |=> running);
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !go) |=> ($stable(prod_hi) && $stable(prod_lo)));
endmodule

bind shiftadd_mul shiftadd_mul_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .go(go), .running(running), .fin(fin),
  .prod_hi(prod_hi), .prod_lo(prod_lo)
);

// File: tb/shiftadd_mul_tb.sv
module shiftadd_mul_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, go = 0;
  logic [31:0] mcand = 0, mplier = 0;
  logic running, fin;
  logic [31:0] prod_hi, prod_lo;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shiftadd_mul dut_i (.clk(clk), .rst_n(rst_n), .go(go), .mcand(mcand), .mplier(mplier),
    .running(running), .fin(fin), .prod_hi(prod_hi), .prod_lo(prod_lo));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // Drives go for one cycle, then checks timing and product; extra_go pulses go mid-run
  task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b,
                        input bit extra_go);
    logic [63:0] exp;
    exp = 64'(a) * 64'(b);
    mcand = a; mplier = b; go = 1;
    tick();
    go = 0;
    for (int i = 1; i <= 32; i++) begin
      chk({req, " R2 running"}, 64'(running), 64'd1);
      chk({req, " R3 fin low"}, 64'(fin), 64'd0);
      if (extra_go && i == 10) begin
        mcand = 32'h1234; mplier = 32'h5678; go = 1;
      end else go = 0;
      tick();
    end
    go = 0;
    chk({req, " R3 fin"}, 64'(fin), 64'd1);
    chk({req, " R2 running low"}, 64'(running), 64'd0);
    chk({req, " R4 product"}, {prod_hi, prod_lo}, exp);
    tick();
    chk({req, " R3 fin single"}, 64'(fin), 64'd0);
    tick(); tick();
    chk({req, " R7 hold"}, {prod_hi, prod_lo}, exp);
  endtask

  task automatic t_reset();
    rst_n = 0; tick(); tick(); rst_n = 1; #0;
    chk("R1 running", 64'(running), 0);
    chk("R1 fin", 64'(fin), 0);
    chk("R1 product", {prod_hi, prod_lo}, 0);
  endtask

  initial begin
    t_reset();
    run_op("R4 basic", 32'd7, 32'd6, 0);
    run_op("R4 mixed", 32'hDEADBEEF, 32'h12345678, 0);
    run_op("R5 allones", 32'hFFFFFFFF, 32'hFFFFFFFF, 0);
    chk("R5 hi word", 64'(prod_hi), 64'hFFFFFFFE);
    run_op("R5 carry", 32'h80000001, 32'hFFFFFFFF, 0);
    run_op("R8 zero", 32'h0, 32'hABCDEF01, 0);
    run_op("R8 zero b", 32'h89ABCDEF, 32'h0, 0);
    run_op("R8 one", 32'h1, 32'hCAFEF00D, 0);
    run_op("R6 busy go", 32'h00010003, 32'h7FFFFFFF, 1);
    repeat (5) tick();
    chk("R7 idle hold", {prod_hi, prod_lo}, 64'(32'h00010003) * 64'(32'h7FFFFFFF));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule